// File: doc/BRIEF.md
# 16-bit Arithmetic and Logic Unit with Compare and Shift

This is the combinational execute-stage unit of a small 16-bit processor. It takes two 16-bit operands, a 4-bit shift amount, a 2-bit mode select and the 3-bit register-register function code. It returns a 16-bit result and a flag that is high when the result is zero. The instruction decoder elsewhere chooses the operands, including any sign-extended immediate, and sets the mode.

With mode 00 the function code chooses the operation. The other modes choose a signed less-than compare, a left shift or a logical right shift. The compare ops use the subtractor's difference and sign bits, so the adder is shared.

Top module: `alu16_core`

## Requirements
- R1: With mode 00 and function 000, the result is A + B modulo 2^16. No overflow is signalled.
- R2: With mode 00 and function 110, the result is A - B modulo 2^16.
- R3: With mode 00, function 001 gives A AND B, function 010 gives A OR B, and function 111 gives A XOR B.
- R4: With mode 00 and function 011, the result is 1 when A equals B and 0 otherwise.
- R5: With mode 00 and function 101, the result is 1 when A <= B as signed two's-complement values, and 0 otherwise.
- R6: With mode 01, the result is 1 when A < B as signed two's-complement values, and 0 otherwise.
- R7: With mode 10, the result is A shifted left by the shift amount, with zeros filled in at the bottom.
- R8: With mode 11, the result is A shifted right logically by the shift amount, with zeros filled in at the top.
- R9: With mode 00 and function 100, the result is 0.
- R10: The zero flag is 1 exactly when the 16-bit result is 0, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand, and the value that is shifted |
| b_i | input | 16 | Second operand |
| shamt_i | input | 4 | Shift amount for modes 10 and 11 |
| mode_i | input | 2 | 00 register-register, 01 less-than, 10 shift left, 11 shift right |
| fn_i | input | 3 | Function code, used only in mode 00 |
| res_o | output | 16 | Result |
| zero_o | output | 1 | High when res_o is zero |

## Verification
The bench aims at the operand pairs where the signed compare disagrees with an unsigned one, such as 0x8000 against 0x7FFF. A design that compared without sign, or read only the sign of the difference, would invert the answer there. Equal operands test the boundary between less-than and less-or-equal, where an off-by-one would flip one of the two. Add and subtract are driven at the wrap points, where a widened adder would leak a carry. Shift amounts of 0 and 15 catch a shifter that fills with the sign bit or drops a stage. The unused function code must give zero with the flag set, and not hold a stale or default value.

// File: rtl/alu16_core.sv
module alu16_core #(
  parameter int W = 16,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [SHW-1:0] shamt_i,
  input  logic [1:0]     mode_i,
  input  logic [2:0]     fn_i,
  output logic [W-1:0]   res_o,
  output logic           zero_o
);
  localparam logic [1:0] M_REG = 2'b00, M_SLT = 2'b01, M_SLL = 2'b10, M_SRL = 2'b11;
  localparam logic [2:0] F_ADD = 3'b000, F_AND = 3'b001, F_OR = 3'b010, F_SEQ = 3'b011,
                         F_NONE = 3'b100, F_SLE = 3'b101, F_SUB = 3'b110, F_XOR = 3'b111;

  logic         use_sub;
  logic [W-1:0] sum, b_eff;
  logic         a_lt_b, a_eq_b;

  assign use_sub = (mode_i != M_REG) || (fn_i != F_ADD);
  assign b_eff   = use_sub ? ~b_i : b_i;
  assign sum     = a_i + b_eff + {{(W-1){1'b0}}, use_sub};
  assign a_eq_b  = (a_i == b_i);
  assign a_lt_b  = (a_i[W-1] != b_i[W-1]) ? a_i[W-1] : sum[W-1];

  logic [W-1:0] stage [SHW+1];
  logic [W-1:0] shl_in, shl_out, srl_out;

  generate
    for (genvar k = 0; k < W; k++) begin : g_rev
      assign shl_in[k]  = (mode_i == M_SRL) ? a_i[W-1-k] : a_i[k];
      assign srl_out[k] = shl_out[W-1-k];
    end
  endgenerate

  assign stage[0] = shl_in;
  generate
    for (genvar s = 0; s < SHW; s++) begin : g_shift
      assign stage[s+1] = shamt_i[s] ? {stage[s][W-1-(1<<s):0], {(1<<s){1'b0}}} : stage[s];
    end
  endgenerate
  assign shl_out = stage[SHW];

  always_comb begin
    res_o = '0;
    unique case (mode_i)
      M_SLT: res_o = {{(W-1){1'b0}}, a_lt_b};
      M_SLL: res_o = shl_out;
      M_SRL: res_o = srl_out;
      default: begin
        unique case (fn_i)
          F_ADD, F_SUB: res_o = sum;
          F_AND:  res_o = a_i & b_i;
          F_OR:   res_o = a_i | b_i;
          F_XOR:  res_o = a_i ^ b_i;
          F_SEQ:  res_o = {{(W-1){1'b0}}, a_eq_b};
          F_SLE:  res_o = {{(W-1){1'b0}}, a_lt_b | a_eq_b};
          F_NONE: res_o = '0;
          default: res_o = '0;
        endcase
      end
    endcase
  end

  assign zero_o = (res_o == '0);

  always_comb begin
    if (!$isunknown({a_i, b_i, shamt_i, mode_i, fn_i})) begin
      p_add_ident_r1: assert (!(mode_i == M_REG && fn_i == F_ADD && b_i == '0) || res_o == a_i);
      p_sub_self_r2:  assert (!(mode_i == M_REG && fn_i == F_SUB && a_eq_b) || zero_o);
      p_seq_match_r4: assert (!(mode_i == M_REG && fn_i == F_SEQ) || res_o == W'(a_i == b_i));
      p_sle_refl_r5:  assert (!(mode_i == M_REG && fn_i == F_SLE && a_i == b_i) || res_o == W'(1));
      p_slt_irrefl_r6: assert (!(mode_i == M_SLT && a_i == b_i) || zero_o);
      p_sll_low_r7:   assert (!(mode_i == M_SLL) || (res_o & ((W'(1) << shamt_i) - W'(1))) == '0);
      p_srl_high_r8:  assert (!(mode_i == M_SRL) || (res_o & ~({W{1'b1}} >> shamt_i)) == '0);
      p_unused_r9:    assert (!(mode_i == M_REG && fn_i == F_NONE) || zero_o);
      p_flag_bin_r10: assert (!(mode_i == M_SLT) || zero_o != res_o[0]);
    end
  end
endmodule

// File: tb/test_alu16_core.sv
module test_alu16_core;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a, b, res;
  logic [3:0]  sh;
  logic [1:0]  mode;
  logic [2:0]  fn;
  logic        zero;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu16_core i_alu16_core (.a_i(a), .b_i(b), .shamt_i(sh), .mode_i(mode), .fn_i(fn),
                           .res_o(res), .zero_o(zero));

  function automatic logic [15:0] model(input logic [1:0] m, input logic [2:0] f,
                                        input logic [15:0] x, input logic [15:0] y,
                                        input logic [3:0] s);
    int sx, sy, ux;
    sx = $signed(x); sy = $signed(y); ux = int'(x);
    case (m)
      2'd1: return (sx < sy) ? 16'd1 : 16'd0;
      2'd2: return 16'((ux * (1 << s)) % 65536);
      2'd3: return 16'(ux / (1 << s));
      default: case (f)
        3'd0: return 16'((int'(x) + int'(y)) % 65536);
        3'd6: return 16'((int'(x) - int'(y) + 65536) % 65536);
        3'd1: return x & y;
        3'd2: return x | y;
        3'd7: return x ^ y;
        3'd3: return (x == y) ? 16'd1 : 16'd0;
        3'd5: return (sx <= sy) ? 16'd1 : 16'd0;
        default: return 16'd0;
      endcase
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] m, input logic [2:0] f);
    case (m)
      2'd1: return "R6";
      2'd2: return "R7";
      2'd3: return "R8";
      default: case (f)
        3'd0: return "R1";
        3'd6: return "R2";
        3'd3: return "R4";
        3'd5: return "R5";
        3'd4: return "R9";
        default: return "R3";
      endcase
    endcase
  endfunction

  task automatic run(input logic [1:0] m, input logic [2:0] f, input logic [15:0] x,
                     input logic [15:0] y, input logic [3:0] s);
    logic [15:0] exp;
    @(posedge clk);
    mode = m; fn = f; a = x; b = y; sh = s;
    exp = model(m, f, x, y, s);
    @(negedge clk);
    n_cmp++;
    if (res !== exp) begin
      n_bad++;
      $display("FAIL %s mode=%0d fn=%0d a=%h b=%h sh=%0d: res actual %h expected %h",
               tag_of(m, f), m, f, x, y, s, res, exp);
    end
    n_cmp++;
    if (zero !== (exp == 16'd0)) begin
      n_bad++;
      $display("FAIL R10 zero flag a=%h b=%h: actual %b expected %b", x, y, zero, exp == 16'd0);
    end
  endtask

  initial begin
    a = '0; b = '0; sh = '0; mode = '0; fn = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_cmp++;
    if (res !== 16'd0 || zero !== 1'b1) begin
      n_bad++;
      $display("FAIL R1 idle inputs: actual %h/%b expected 0000/1", res, zero);
    end
    // R1 R2 wrap corners
    run(2'd0, 3'd0, 16'hFFFF, 16'h0001, 4'd0);
    run(2'd0, 3'd0, 16'h7FFF, 16'h0001, 4'd0);
    run(2'd0, 3'd6, 16'h0000, 16'h0001, 4'd0);
    run(2'd0, 3'd6, 16'h8000, 16'h0001, 4'd0);
    run(2'd0, 3'd6, 16'h1234, 16'h1234, 4'd0);
    // R4 R5 R6 signed corners
    run(2'd0, 3'd3, 16'hABCD, 16'hABCD, 4'd0);
    run(2'd0, 3'd3, 16'hABCD, 16'hABCC, 4'd0);
    run(2'd0, 3'd5, 16'h8000, 16'h7FFF, 4'd0);
    run(2'd0, 3'd5, 16'h7FFF, 16'h8000, 4'd0);
    run(2'd0, 3'd5, 16'hFFFF, 16'hFFFF, 4'd0);
    run(2'd1, 3'd0, 16'h8000, 16'h7FFF, 4'd0);
    run(2'd1, 3'd0, 16'h7FFF, 16'h8000, 4'd0);
    run(2'd1, 3'd0, 16'h0005, 16'h0005, 4'd0);
    run(2'd1, 3'd0, 16'hFFFF, 16'h0000, 4'd0);
    // R7 R8 shift extremes
    run(2'd2, 3'd0, 16'h8001, 16'h0000, 4'd0);
    run(2'd2, 3'd0, 16'h8001, 16'h0000, 4'd15);
    run(2'd3, 3'd0, 16'h8001, 16'h0000, 4'd15);
    run(2'd3, 3'd0, 16'hF000, 16'h0000, 4'd4);
    // R9 unused code
    run(2'd0, 3'd4, 16'hFFFF, 16'hFFFF, 4'd7);
    // random sweep over every op (R1..R10)
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] m;
      logic [2:0] f;
      m = 2'($urandom_range(0, 3));
      f = 3'($urandom_range(0, 7));
      run(m, f, 16'($urandom), (i % 7 == 0) ? 16'd0 : 16'($urandom), 4'($urandom));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule